// File: doc/BRIEF.md
# Synchronous Memory Read Port

This block is the read side of a small register-array memory. The storage array sits outside it: the array decodes the read address and presents the selected word on `stored_word`. The block turns that word into the port's data output. By default the output is a register that loads on the active clock edge when the read is enabled. A parameter can instead make the port combinational, so the output simply follows the array.

The port also sees the address, bit enables and data of every write port in the same clock domain. When a write and this read hit the same address on the same edge, each write port is handled by its own setting. A forwarding port sends its newly written bits straight to the output. A collision port makes the hit bits undefined; this implementation returns the old stored bits there. Any other port returns the old stored word. Bit i of each mask belongs to write port i.

The output register has three reset-related settings: an asynchronous reset value, a synchronous reset value and a power-up value. A parameter decides whether the read enable must be high for the synchronous reset to act.

Top module: `mrp_read_port`

## Requirements
- R1: With `USE_CLK` = 0, `rd_data` equals `stored_word` at all times and does not wait for a clock edge.
- R2: In clocked mode, an active edge with `rd_en` = 1, `srst` = 0 and no write hit loads `stored_word` into `rd_data`.
- R3: For a write port whose bit is set in `FWD_MASK` (bit i = write port i), a write to the read address on the same edge puts that port's data on the output bits where its bit enables are 1. The other bits keep the stored value. A write to a different address has no effect.
- R4: For a write port whose bit is set in `XCOL_MASK` (bit i = write port i), a same-address, same-edge write makes the enabled output bits undefined. All other bits still return the stored value, and a write to a different address has no effect.
- R5: While `arst` = 1 the output equals `ARST_VAL` at once, with no clock edge needed, whatever the other inputs do.
- R6: An active edge with `srst` = 1 loads `SRST_VAL` when `EN_GATES_SRST` = 0, whatever the state of `rd_en`. This takes precedence over the read and any forwarding.
- R7: With `EN_GATES_SRST` = 1, `srst` acts only when `rd_en` = 1. If `rd_en` = 0 the output holds.
- R8: Before any reset or enabled edge, the clocked output equals `INIT_VAL`.
- R9: An active edge with `rd_en` = 0 and no effective reset leaves `rd_data` unchanged.
- R10: A write port set in neither mask that hits the read address on the same edge does not change the result: the old stored word is returned.
- R11: `RISING` = 1 updates on the rising edge only. `RISING` = 0 updates on the falling edge only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; the active edge is set by `RISING` |
| arst | input | 1 | Asynchronous reset, active high |
| srst | input | 1 | Synchronous reset, active high |
| rd_en | input | 1 | Read enable |
| rd_addr | input | ADDR_W | Read address, compared against the write addresses |
| stored_word | input | DATA_W | Word the array holds at `rd_addr` |
| wr_bit_en | input | NUM_WR*DATA_W | Per-bit write enables; port i occupies bits [i*DATA_W +: DATA_W] |
| wr_addr | input | NUM_WR*ADDR_W | Write addresses; port i occupies bits [i*ADDR_W +: ADDR_W] |
| wr_data | input | NUM_WR*DATA_W | Write data; port i occupies bits [i*DATA_W +: DATA_W] |
| rd_data | output | DATA_W | Read data |

## Verification
The bench drives one write port of each kind at the read address on the same edge. A design that mixed up the mask index would forward from the wrong port, or return new data where old data is required. Partial bit enables are used to catch forwarding done by whole words. Writes to nearby addresses must have no effect, and a forwarding write together with a synchronous reset must leave the reset value, which exposes a wrong precedence. Copies of the port clocked on the opposite edge, with enable-gated synchronous reset, and in combinational mode show any edge, gating or clock-dependence mistake as a mismatch at a half-cycle sample point.

// File: rtl/mrp_pkg.sv
package mrp_pkg;

    // Where one output bit takes its value from
    typedef enum logic [1:0] {
        SRC_OLD   = 2'd0,
        SRC_NEW   = 2'd1,
        SRC_UNDEF = 2'd2
    } bit_src_e;

    // Decoded register update for one active edge
    typedef struct packed {
        logic take_srst;
        logic take_read;
    } upd_t;

    function automatic bit_src_e classify(logic fwd, logic undef);
        if (undef)
            return SRC_UNDEF;
        else if (fwd)
            return SRC_NEW;
        return SRC_OLD;
    endfunction

    // Undefined bits are realised as the old stored bit
    function automatic logic pick_bit(bit_src_e src, logic old_b, logic new_b);
        case (src)
            SRC_NEW: return new_b;
            default: return old_b;
        endcase
    endfunction

    function automatic upd_t decode_update(logic en, logic srst, logic gate);
        upd_t u;
        u.take_srst = srst & (en | ~gate);
        u.take_read = en & ~u.take_srst;
        return u;
    endfunction

endpackage

// File: rtl/mrp_hit_detect.sv
module mrp_hit_detect #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int NUM_WR = 3,
    parameter logic [NUM_WR-1:0] FWD_MASK  = 3'b001,
    parameter logic [NUM_WR-1:0] XCOL_MASK = 3'b010
) (
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic [NUM_WR*DATA_W-1:0] wr_bit_en,
    input  logic [NUM_WR*ADDR_W-1:0] wr_addr,
    input  logic [NUM_WR*DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0]        fwd_bits,
    output logic [DATA_W-1:0]        fwd_data,
    output logic [DATA_W-1:0]        undef_bits
);

    logic [DATA_W-1:0] port_sel [NUM_WR];

    // Per-port same-address hit, qualified by that port's bit enables
    for (genvar g = 0; g < NUM_WR; g++) begin : g_port
        logic hit;
        assign hit         = (wr_addr[g*ADDR_W +: ADDR_W] == rd_addr);
        assign port_sel[g] = hit ? wr_bit_en[g*DATA_W +: DATA_W] : '0;
    end

    // Higher port index wins where forwarding ports overlap
    always_comb begin
        fwd_bits   = '0;
        fwd_data   = '0;
        undef_bits = '0;
        for (int i = 0; i < NUM_WR; i++) begin
            if (FWD_MASK[i]) begin
                fwd_bits = fwd_bits | port_sel[i];
                fwd_data = (fwd_data & ~port_sel[i])
                         | (wr_data[i*DATA_W +: DATA_W] & port_sel[i]);
            end else if (XCOL_MASK[i]) begin
                undef_bits = undef_bits | port_sel[i];
            end
        end
    end

endmodule

// File: rtl/mrp_word_merge.sv
module mrp_word_merge
    import mrp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] stored_word,
    input  logic [DATA_W-1:0] fwd_bits,
    input  logic [DATA_W-1:0] fwd_data,
    input  logic [DATA_W-1:0] undef_bits,
    output logic [DATA_W-1:0] merged
);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        bit_src_e src;
        assign src       = classify(fwd_bits[b], undef_bits[b]);
        assign merged[b] = pick_bit(src, stored_word[b], fwd_data[b]);
    end

endmodule

// File: rtl/mrp_out_reg.sv
module mrp_out_reg
    import mrp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter bit RISING = 1'b1,
    parameter bit EN_GATES_SRST = 1'b0,
    parameter logic [DATA_W-1:0] ARST_VAL = 8'hA5,
    parameter logic [DATA_W-1:0] SRST_VAL = 8'h3C,
    parameter logic [DATA_W-1:0] INIT_VAL = 8'h5A
) (
    input  logic              clk,
    input  logic              arst,
    input  logic              srst,
    input  logic              en,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);

    upd_t upd;
    logic [DATA_W-1:0] q_r = INIT_VAL;

    assign upd = decode_update(en, srst, EN_GATES_SRST);

    if (RISING) begin : g_rise
        always_ff @(posedge clk or posedge arst) begin
            if (arst)
                q_r <= ARST_VAL;
            else if (upd.take_srst)
                q_r <= SRST_VAL;
            else if (upd.take_read)
                q_r <= d;
        end
    end else begin : g_fall
        always_ff @(negedge clk or posedge arst) begin
            if (arst)
                q_r <= ARST_VAL;
            else if (upd.take_srst)
                q_r <= SRST_VAL;
            else if (upd.take_read)
                q_r <= d;
        end
    end

    assign q = q_r;

endmodule

// File: rtl/mrp_read_port.sv
module mrp_read_port #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int NUM_WR = 3,
    parameter bit USE_CLK = 1'b1,
    parameter bit RISING = 1'b1,
    parameter logic [NUM_WR-1:0] FWD_MASK  = 3'b001,
    parameter logic [NUM_WR-1:0] XCOL_MASK = 3'b010,
    parameter logic [DATA_W-1:0] ARST_VAL = 8'hA5,
    parameter logic [DATA_W-1:0] SRST_VAL = 8'h3C,
    parameter logic [DATA_W-1:0] INIT_VAL = 8'h5A,
    parameter bit EN_GATES_SRST = 1'b0
) (
    input  logic                     clk,
    input  logic                     arst,
    input  logic                     srst,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic [DATA_W-1:0]        stored_word,
    input  logic [NUM_WR*DATA_W-1:0] wr_bit_en,
    input  logic [NUM_WR*ADDR_W-1:0] wr_addr,
    input  logic [NUM_WR*DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0]        rd_data
);

    logic [DATA_W-1:0] fwd_bits;
    logic [DATA_W-1:0] fwd_data;
    logic [DATA_W-1:0] undef_bits;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] reg_q;

    mrp_hit_detect #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WR(NUM_WR),
        .FWD_MASK(FWD_MASK), .XCOL_MASK(XCOL_MASK)
    ) u_hit (
        .rd_addr(rd_addr), .wr_bit_en(wr_bit_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .fwd_bits(fwd_bits), .fwd_data(fwd_data),
        .undef_bits(undef_bits)
    );

    mrp_word_merge #(.DATA_W(DATA_W)) u_merge (
        .stored_word(stored_word), .fwd_bits(fwd_bits), .fwd_data(fwd_data),
        .undef_bits(undef_bits), .merged(merged)
    );

    mrp_out_reg #(
        .DATA_W(DATA_W), .RISING(RISING), .EN_GATES_SRST(EN_GATES_SRST),
        .ARST_VAL(ARST_VAL), .SRST_VAL(SRST_VAL), .INIT_VAL(INIT_VAL)
    ) u_oreg (
        .clk(clk), .arst(arst), .srst(srst), .en(rd_en), .d(merged), .q(reg_q)
    );

    if (USE_CLK) begin : g_sync
        assign rd_data = reg_q;
    end else begin : g_comb
        assign rd_data = stored_word;
    end

endmodule

// File: rtl/mrp_read_port_chk.sv
module mrp_read_port_chk #(
    parameter int DATA_W = 8,
    parameter int NUM_WR = 3,
    parameter bit USE_CLK = 1'b1,
    parameter bit RISING = 1'b1,
    parameter logic [DATA_W-1:0] ARST_VAL = 8'hA5,
    parameter logic [DATA_W-1:0] SRST_VAL = 8'h3C,
    parameter bit EN_GATES_SRST = 1'b0
) (
    input logic                     clk,
    input logic                     arst,
    input logic                     srst,
    input logic                     rd_en,
    input logic [DATA_W-1:0]        stored_word,
    input logic [NUM_WR*DATA_W-1:0] wr_bit_en,
    input logic [DATA_W-1:0]        rd_data
);

    if (USE_CLK && RISING) begin : g_rise_props
        // R5: output pinned to the asynchronous value mid-cycle
        always @(negedge clk) begin
            if (arst)
                p_arst_hold_r5: assert (rd_data == ARST_VAL);
        end

        // R6 / R7: effective synchronous reset loads its value
        p_srst_load_r6: assert property (@(posedge clk) disable iff (arst)
            (srst && (rd_en || !EN_GATES_SRST)) |=> (rd_data == SRST_VAL));

        // R9 / R7: no enable and no effective reset keeps the output
        p_idle_hold_r9: assert property (@(posedge clk) disable iff (arst)
            (!rd_en && (!srst || EN_GATES_SRST)) |=> $stable(rd_data));

        // R2: plain read with no write activity returns the stored word
        p_plain_read_r2: assert property (@(posedge clk) disable iff (arst)
            (rd_en && !srst && (wr_bit_en == '0)) |=> (rd_data == $past(stored_word)));
    end

endmodule

bind mrp_read_port mrp_read_port_chk #(
    .DATA_W(DATA_W), .NUM_WR(NUM_WR), .USE_CLK(USE_CLK), .RISING(RISING),
    .ARST_VAL(ARST_VAL), .SRST_VAL(SRST_VAL), .EN_GATES_SRST(EN_GATES_SRST)
) u_chk (
    .clk(clk), .arst(arst), .srst(srst), .rd_en(rd_en),
    .stored_word(stored_word), .wr_bit_en(wr_bit_en), .rd_data(rd_data)
);

// File: tb/test_mrp_read_port.sv
module test_mrp_read_port;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 14;
    localparam logic [7:0] AV = 8'hA5;
    localparam logic [7:0] SV = 8'h3C;
    localparam logic [7:0] IV = 8'h5A;

    typedef struct packed {
        logic            en;
        logic            srst;
        logic [3:0]      addr;
        logic [7:0]      stored;
        logic [23:0]     we;   // {port2, port1, port0}
        logic [11:0]     wa;
        logic [23:0]     wd;
        logic [7:0]      exp;
        logic [7:0]      dc;
    } vec_t;

    // port0 forwards, port1 collides, port2 neither
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,4'h3,8'h11,{8'h00,8'h00,8'h00},{4'h0,4'h0,4'h0},{8'h00,8'h00,8'h00},8'h11,8'h00},
        '{1'b0,1'b0,4'h3,8'h22,{8'h00,8'h00,8'h00},{4'h0,4'h0,4'h0},{8'h00,8'h00,8'h00},8'h11,8'h00},
        '{1'b1,1'b0,4'h4,8'h33,{8'h00,8'h00,8'hFF},{4'h0,4'h0,4'h4},{8'h00,8'h00,8'hC7},8'hC7,8'h00},
        '{1'b1,1'b0,4'h4,8'h33,{8'h00,8'h00,8'h0F},{4'h0,4'h0,4'h4},{8'h00,8'h00,8'hC7},8'h37,8'h00},
        '{1'b1,1'b0,4'h4,8'h33,{8'h00,8'h00,8'hFF},{4'h0,4'h0,4'h5},{8'h00,8'h00,8'hC7},8'h33,8'h00},
        '{1'b1,1'b0,4'h6,8'h44,{8'hFF,8'h00,8'h00},{4'h6,4'h0,4'h0},{8'h99,8'h00,8'h00},8'h44,8'h00},
        '{1'b1,1'b0,4'h6,8'h44,{8'h00,8'hF0,8'h00},{4'h0,4'h6,4'h0},{8'h00,8'h99,8'h00},8'h44,8'hF0},
        '{1'b1,1'b0,4'h6,8'h44,{8'h00,8'hFF,8'h00},{4'h0,4'h7,4'h0},{8'h00,8'h99,8'h00},8'h44,8'h00},
        '{1'b1,1'b1,4'h2,8'h55,{8'h00,8'h00,8'hFF},{4'h0,4'h0,4'h2},{8'h00,8'h00,8'h66},8'h3C,8'h00},
        '{1'b1,1'b0,4'h1,8'h81,{8'h00,8'h00,8'h00},{4'h0,4'h0,4'h0},{8'h00,8'h00,8'h00},8'h81,8'h00},
        '{1'b0,1'b1,4'h1,8'h88,{8'h00,8'h00,8'h00},{4'h0,4'h0,4'h0},{8'h00,8'h00,8'h00},8'h3C,8'h00},
        '{1'b1,1'b0,4'h9,8'h12,{8'hFF,8'h00,8'hFF},{4'h9,4'h0,4'h9},{8'hCD,8'h00,8'hAB},8'hAB,8'h00},
        '{1'b1,1'b0,4'hA,8'h0F,{8'h00,8'h0F,8'hF0},{4'h0,4'hA,4'hA},{8'h00,8'h01,8'hE0},8'hE0,8'h0F},
        '{1'b1,1'b0,4'h0,8'hFE,{8'h00,8'h00,8'h00},{4'h0,4'h0,4'h0},{8'h00,8'h00,8'h00},8'hFE,8'h00}
    };

    localparam string TAG [NV] = '{"R2","R9","R3","R3","R3","R10","R4",
                                   "R4","R6","R2","R6","R10","R4","R2"};

    logic        clk = 1'b0;
    logic        arst = 1'b0;
    logic        srst = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [7:0]  stored_word = '0;
    logic [23:0] wr_bit_en = '0;
    logic [11:0] wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic [7:0]  q_main, q_gate, q_fall, q_comb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mrp_read_port i_mrp_read_port (
        .clk(clk), .arst(arst), .srst(srst), .rd_en(rd_en), .rd_addr(rd_addr),
        .stored_word(stored_word), .wr_bit_en(wr_bit_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_data(q_main)
    );

    mrp_read_port #(.EN_GATES_SRST(1'b1)) i_gated (
        .clk(clk), .arst(arst), .srst(srst), .rd_en(rd_en), .rd_addr(rd_addr),
        .stored_word(stored_word), .wr_bit_en(wr_bit_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_data(q_gate)
    );

    mrp_read_port #(.RISING(1'b0)) i_falling (
        .clk(clk), .arst(arst), .srst(srst), .rd_en(rd_en), .rd_addr(rd_addr),
        .stored_word(stored_word), .wr_bit_en(wr_bit_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_data(q_fall)
    );

    mrp_read_port #(.USE_CLK(1'b0)) i_comb (
        .clk(clk), .arst(arst), .srst(srst), .rd_en(rd_en), .rd_addr(rd_addr),
        .stored_word(stored_word), .wr_bit_en(wr_bit_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_data(q_comb)
    );

    task automatic chk(string tag, string what, logic [7:0] act,
                       logic [7:0] exp, logic [7:0] dc);
        checks++;
        if (((act ^ exp) & ~dc) != 8'h00) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h (dont-care %h)",
                     tag, what, act, exp, dc);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] prev_exp, prev_dc, gprev, gprev_dc, gexp, gdc;

        // R8: power-up value before any edge
        #2;
        chk("R8", "main init", q_main, IV, 8'h00);
        chk("R8", "falling init", q_fall, IV, 8'h00);

        // R5: asynchronous reset acts with no edge
        arst = 1'b1;
        #1;
        chk("R5", "main async", q_main, AV, 8'h00);
        chk("R5", "falling async", q_fall, AV, 8'h00);
        @(posedge clk); #2;
        @(posedge clk); #2;
        arst = 1'b0;

        prev_exp = AV; prev_dc = 8'h00;
        gprev = AV; gprev_dc = 8'h00;

        for (int k = 0; k < NV; k++) begin
            rd_en       = VEC[k].en;
            srst        = VEC[k].srst;
            rd_addr     = VEC[k].addr;
            stored_word = VEC[k].stored;
            wr_bit_en   = VEC[k].we;
            wr_addr     = VEC[k].wa;
            wr_data     = VEC[k].wd;
            // R7: enable-gated reset ignores srst when rd_en is low
            gexp = (VEC[k].srst && !VEC[k].en) ? gprev : VEC[k].exp;
            gdc  = (VEC[k].srst && !VEC[k].en) ? gprev_dc : VEC[k].dc;

            @(negedge clk); #2;
            chk("R11", "rising port ignores falling edge", q_main, prev_exp, prev_dc);
            chk(TAG[k], "falling port vector", q_fall, VEC[k].exp, VEC[k].dc);
            chk("R1", "comb follows array", q_comb, VEC[k].stored, 8'h00);

            @(posedge clk); #2;
            chk(TAG[k], "rising port vector", q_main, VEC[k].exp, VEC[k].dc);
            chk("R7", "gated port vector", q_gate, gexp, gdc);
            chk("R11", "falling port ignores rising edge", q_fall, VEC[k].exp, VEC[k].dc);

            prev_exp = VEC[k].exp; prev_dc = VEC[k].dc;
            gprev = gexp; gprev_dc = gdc;
        end

        // R5: reset overrides an enabled read and holds across edges
        wr_bit_en = '0;
        rd_en = 1'b1; srst = 1'b0; stored_word = 8'hF0;
        arst = 1'b1;
        #1;
        chk("R5", "main mid-cycle", q_main, AV, 8'h00);
        chk("R5", "gated mid-cycle", q_gate, AV, 8'h00);
        @(posedge clk); #2;
        chk("R5", "main over enabled edge", q_main, AV, 8'h00);
        @(negedge clk); #2;
        chk("R5", "falling over enabled edge", q_fall, AV, 8'h00);
        @(posedge clk); #2;
        rd_en = 1'b0;
        arst = 1'b0;
        @(posedge clk); #2;
        chk("R9", "hold after reset release", q_main, AV, 8'h00);

        // R1: combinational port tracks the array with no edge
        stored_word = 8'h5E;
        #1;
        chk("R1", "comb immediate 5E", q_comb, 8'h5E, 8'h00);
        stored_word = 8'h61;
        #1;
        chk("R1", "comb immediate 61", q_comb, 8'h61, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule